// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is a register-mapped countdown timer with a single interrupt line. Software first writes an interval word. It then fires one of two start triggers. One trigger runs a single countdown. The other runs a countdown that reloads itself and repeats until it is halted. On each expiry the timer raises a sticky pending flag, and the `irq` output follows that flag. Software lowers the flag through an acknowledge trigger and cancels a running countdown through a halt trigger.

The bus is word addressed and carries a write strobe, a 3-bit word index, write data and combinational read data. Each trigger word responds only to a nonzero write value. A status word reports the running state and the pending state. The counter decrements once per clock with no prescaler. A countdown started with interval N therefore expires on the (N+1)-th rising edge after the start write. A periodic countdown then expires again every N+1 edges and reloads from the interval word at each expiry. There is no streaming data path, so every pin is a plain control or status signal and no valid/ready handshake is needed.

Top module: `countdown_timer`

## Requirements
- R1: After reset the status word reads 0, `irq` is 0 and the interval word reads 0.
- R2: Word 3 (byte offset 12) holds the interval and reads back what was written. Word 0 returns status with bit 0 = running and bit 1 = pending, and zeros above. Every other word reads 0.
- R3: A nonzero write to word 4 (byte offset 16) loads the interval and starts a single countdown. Pending rises on the (N+1)-th edge after the write, and running clears at that same edge.
- R4: A nonzero write to word 5 (byte offset 20) starts a periodic countdown. It first expires N+1 edges after the write and then every N+1 edges after that, reloads from the interval word and stays running.
- R5: A nonzero write to word 1 (byte offset 4) clears running at that edge. No expiry follows, including one that falls due in the same cycle.
- R6: A nonzero write to word 2 (byte offset 8) clears pending at that edge.
- R7: Writing zero to word 1, 2, 4 or 5 changes neither running, pending, mode nor the count in progress.
- R8: Pending is sticky. It stays set across further expiries until it is acknowledged, and `irq` always equals pending.
- R9: An interval of 0 expires on the first edge after the start write.
- R10: When an acknowledge and an expiry occur in the same cycle, pending remains set.
- R11: A start write while a countdown is running restarts it from the current interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, equal to the pending flag |

## Verification
A wrong count, mode or reload value shows up as an expiry on the wrong edge. The bench catches it within one interval by counting the edges from the start write to the rise of `irq` and comparing that count with N+1. A wrong running or mode bit becomes visible in the status word on the edge after the expiry or trigger that should have changed it. A lost sticky flag or a lost acknowledge shows on `irq` one edge later. A trigger that wrongly acts on zero data moves the next expiry or alters the status word. Both of those are observed before the next stimulus is applied.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned ST_RUN_BIT  = 0;
  localparam int unsigned ST_PEND_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    W_STATUS   = 3'd0,
    W_HALT     = 3'd1,
    W_ACK      = 3'd2,
    W_INTERVAL = 3'd3,
    W_GO_ONCE  = 3'd4,
    W_GO_LOOP  = 3'd5
  } word_e;

  typedef struct packed {
    logic go_once;
    logic go_loop;
    logic halt;
    logic ack;
  } cmd_t;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running,
  input  logic              pending,
  output cmd_t              cmd,
  output logic [CNT_W-1:0]  interval,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic nz;
  assign nz = |wdata;

  always_comb begin
    cmd         = '0;
    cmd.halt    = we && nz && (addr == W_HALT);
    cmd.ack     = we && nz && (addr == W_ACK);
    cmd.go_once = we && nz && (addr == W_GO_ONCE);
    cmd.go_loop = we && nz && (addr == W_GO_LOOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           interval <= '0;
    else if (we && addr == W_INTERVAL)    interval <= wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      W_STATUS: begin
        rdata[ST_RUN_BIT]  = running;
        rdata[ST_PEND_BIT] = pending;
      end
      W_INTERVAL: begin
        if (PAD_W > 0) rdata = {{PAD_W{1'b0}}, interval};
        else           rdata = interval;
      end
      default: rdata = '0;
    endcase
  end

  // R7
  zero_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == '0) |-> (cmd == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd,
  input  logic [CNT_W-1:0] interval,
  output logic             running,
  output logic             expire
);
  logic             loop_mode;
  logic [CNT_W-1:0] count;
  logic             go;

  assign go     = cmd.go_once | cmd.go_loop;
  assign expire = running && (count == '0) && !cmd.halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      loop_mode <= 1'b0;
      count     <= '0;
    end else if (cmd.halt) begin
      running   <= 1'b0;
    end else if (go) begin
      running   <= 1'b1;
      loop_mode <= cmd.go_loop;
      count     <= interval;
    end else if (running) begin
      if (count == '0) begin
        count   <= interval;
        running <= loop_mode;
      end else begin
        count   <= count - 1'b1;
      end
    end
  end

  // R3
  once_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !loop_mode && !go) |=> !running);

  // R4
  loop_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && loop_mode && !go) |=> (running && count == $past(interval)));

  // R5
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.halt |=> !running);

  // R11
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cmd.halt) |=> (running && count == $past(interval)));
endmodule

// File: rtl/cdt_flag.sv
module cdt_flag
  import cdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (ack)    pending <= 1'b0;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);

  // R10
  expire_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ack) |=> pending);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !pending);
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  cmd_t             cmd;
  logic [CNT_W-1:0] interval;
  logic             running;
  logic             pending;
  logic             expire;

  cdt_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .running(running), .pending(pending), .cmd(cmd), .interval(interval),
    .rdata(bus_rdata)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .interval(interval),
    .running(running), .expire(expire)
  );

  cdt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack(cmd.ack), .pending(pending)
  );

  assign irq = pending;

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire));
endmodule

// File: tb/countdown_timer_test.sv
`timescale 1ns/1ps
module countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 3'd0;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (irq !== 1'b1 && n < lim) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    rd(3'd0, v); check("R1 status", v, 0);
    rd(3'd3, v); check("R1 interval", v, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    idle(1);

    // R2 register access
    wr(3'd3, 32'hA5A5_1234);
    rd(3'd3, v); check("R2 interval readback", v, 32'hA5A5_1234);
    for (int a = 1; a < 8; a++) begin
      if (a != 3) begin rd(a[2:0], v); check("R2 unused word reads 0", v, 0); end
    end

    // R3 / R9 one-shot sweep, N = 0..15
    for (int N = 0; N < 16; N++) begin
      wr(3'd3, N); wr(3'd2, 1); wr(3'd4, 1);
      wait_irq(N + 5, n);
      check(N == 0 ? "R9 zero interval delay" : "R3 one-shot delay", n, N + 1);
      rd(3'd0, v); check("R3 status after one-shot", v, 2);
    end

    // R4 / R6 periodic sweep, N = 1..6
    for (int N = 1; N < 7; N++) begin
      wr(3'd3, N); wr(3'd2, 1); wr(3'd5, 1);
      wait_irq(N + 5, n); check("R4 first period", n, N + 1);
      rd(3'd0, v); check("R4 still running", v, 3);
      wr(3'd2, 1); check("R6 ack clears irq", irq, 0);
      wait_irq(N + 5, n); check("R4 next period", n, N);
      wr(3'd1, 1); wr(3'd2, 1);
      idle(3 * N + 3);
      check("R5 no expiry after halt", irq, 0);
      rd(3'd0, v); check("R5 status after halt", v, 0);
    end

    // R5 halt mid-count
    wr(3'd3, 10); wr(3'd4, 1); idle(3); wr(3'd1, 1);
    rd(3'd0, v); check("R5 running cleared", v, 0);
    idle(20); check("R5 irq stays low", irq, 0);

    // R7 zero writes are inert
    wr(3'd4, 1);               // start at edge k
    wr(3'd1, 0); wr(3'd4, 0); wr(3'd5, 0); wr(3'd2, 0);
    wait_irq(20, n); check("R7 timing unchanged by zero writes", n, 7);
    rd(3'd0, v); check("R7 mode stays one-shot", v, 2);
    wr(3'd2, 0); check("R7 zero ack keeps irq", irq, 1);
    wr(3'd2, 1); check("R6 ack", irq, 0);

    // R8 sticky across many expiries
    wr(3'd3, 2); wr(3'd5, 1); idle(14);
    check("R8 irq sticky", irq, 1);
    rd(3'd0, v); check("R8 status sticky", v, 3);
    wr(3'd1, 1); wr(3'd2, 1);

    // R10 ack collides with expiry
    wr(3'd3, 4); wr(3'd4, 1); idle(4); wr(3'd2, 1);
    check("R10 expiry wins over ack", irq, 1);
    wr(3'd2, 1); check("R10 later ack clears", irq, 0);

    // R11 restart while running
    wr(3'd3, 8); wr(3'd4, 1); idle(5); wr(3'd4, 1);
    wait_irq(20, n); check("R11 restart delay", n, 9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule